// File: doc/BRIEF.md
# Chained Watchpoint and Event Counter Unit

This unit sits beside a set of address/data comparators in a processor debug block. It turns eight comparator hit lines, two counter-equals-limit conditions and one external hit line into eleven watchpoints. Each watchpoint can be configured to stand on its own source, to AND it with the preceding watchpoint or to OR it with the preceding watchpoint. As a result, conditions such as "address A was reached and then data D was stored" can be built as a chain.

The chain is evaluated only when the evaluate strobe is high. On that strobe the unit compares the new results with the results of the previous evaluation. Each watchpoint that has just turned on may add one to one of two 16-bit event counters, and may request a breakpoint. The two counters feed back into the chain: watchpoints 8 and 9 each fire when their counter reaches its programmed limit. This makes "break on the Nth occurrence" conditions possible. Configuration is loaded through a simple write-only port.

Top module: `wpchain_unit`

## Requirements
- R1: After reset, the watchpoint vector is all zero, both counts are zero and the breakpoint output is low. All configuration registers reset to zero.
- R2: Each watchpoint has a 2-bit link code. Code 0 makes the watchpoint equal to its own source. Code 3 makes it never match.
- R3: Link code 1 ANDs the own source with the result of the preceding watchpoint, and code 2 ORs them. Watchpoint 0 uses its own source as the preceding term.
- R4: Watchpoints 0 to 7 take hit_i bits 0 to 7 as their sources. Watchpoint 8 uses "counter 0 count equals its limit" and watchpoint 9 uses the same condition for counter 1. Both use the counter values as held before the evaluation.
- R5: Watchpoint 10 takes ext_hit_i as its own source, chained to watchpoint 9.
- R6: wp_o is loaded with all eleven results on a cycle with eval_i high, and holds its value otherwise.
- R7: A watchpoint acts only when it newly asserts, meaning it matches now and its wp_o bit is 0. Its select bit (0 = counter 0, 1 = counter 1) picks a counter, which advances only when that counter's enable bit is set.
- R8: When several watchpoints newly assert toward the same counter in one evaluation, the counter advances by their number.
- R9: brk_o is high for exactly the one cycle after an evaluation in which some newly asserting watchpoint has its break bit set. No pulse follows otherwise.
- R10: The write port is decoded by wr_addr_i as follows:
  - 0: link codes, bits [2i+1:2i] for watchpoint i.
  - 1: counter select bits [10:0].
  - 2: break bits [10:0].
  - 3: counter enables, bit 0 for counter 0 and bit 1 for counter 1.
  - 4 and 5: counter 0 and counter 1, with the count in bits [15:0] and the limit in bits [31:16].
  - 6 and 7: writes have no effect.
  A counter write in the same cycle as an increment wins.
- R11: Counts wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | NHIT (8) | Comparator hit lines, own sources of watchpoints 0..7 |
| ext_hit_i | input | 1 | External hit, own source of watchpoint 10 |
| eval_i | input | 1 | Evaluate strobe |
| wr_en_i | input | 1 | Configuration write enable |
| wr_addr_i | input | AW (3) | Configuration register select |
| wr_data_i | input | 2*CW (32) | Configuration write data |
| wp_o | output | NHIT+3 (11) | Watchpoint results of the last evaluation |
| cnt0_o | output | CW (16) | Counter 0 count |
| cnt1_o | output | CW (16) | Counter 1 count |
| brk_o | output | 1 | One-cycle breakpoint request |

## Verification
The bench builds the unit with NHIT=8 and CW=16, which gives the full eleven-link chain with all three special links present. Because the counter width is 16 bits, wrap-around is reached by preloading a count of 0xFFFF through the write port rather than by counting 65536 events. With that same width, the limit feedback into watchpoints 8 and 9 is reached by preloading the count one below the limit. All other cases, including several watchpoints rising into one counter and a counter write colliding with an increment, are driven within a few dozen cycles.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    LNK_SOLO = 2'd0,
    LNK_AND  = 2'd1,
    LNK_OR   = 2'd2,
    LNK_OFF  = 2'd3
  } link_e;

  localparam logic [2:0] RA_LINK = 3'd0;
  localparam logic [2:0] RA_CSEL = 3'd1;
  localparam logic [2:0] RA_BRK  = 3'd2;
  localparam logic [2:0] RA_CEN  = 3'd3;
  localparam logic [2:0] RA_CNT0 = 3'd4;
  localparam logic [2:0] RA_CNT1 = 3'd5;

endpackage

// File: rtl/wpc_regs.sv
module wpc_regs
  import wpc_pkg::*;
#(
  parameter int unsigned NWP = 11,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [2*NWP-1:0] link_q,
  output logic [NWP-1:0]   csel_q,
  output logic [NWP-1:0]   brk_q,
  output logic [1:0]       cen_q,
  output logic [1:0]       cnt_ld
);

  logic link_en, csel_en, brk_en, cen_en;

  // decode of the write port; unmapped addresses select nothing
  always_comb begin
    link_en   = wr_en && (wr_addr == AW'(RA_LINK));
    csel_en   = wr_en && (wr_addr == AW'(RA_CSEL));
    brk_en    = wr_en && (wr_addr == AW'(RA_BRK));
    cen_en    = wr_en && (wr_addr == AW'(RA_CEN));
    cnt_ld[0] = wr_en && (wr_addr == AW'(RA_CNT0));
    cnt_ld[1] = wr_en && (wr_addr == AW'(RA_CNT1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= '0;
      csel_q <= '0;
      brk_q  <= '0;
      cen_q  <= '0;
    end else begin
      if (link_en) link_q <= wr_data[2*NWP-1:0];
      if (csel_en) csel_q <= wr_data[NWP-1:0];
      if (brk_en)  brk_q  <= wr_data[NWP-1:0];
      if (cen_en)  cen_q  <= wr_data[1:0];
    end
  end

endmodule

// File: rtl/wpc_chain.sv
module wpc_chain
  import wpc_pkg::*;
#(
  parameter int unsigned NWP = 11
) (
  input  logic [NWP-1:0]   own,
  input  logic [2*NWP-1:0] link,
  output logic [NWP-1:0]   match
);

  function automatic logic link_eval(input logic [1:0] code, input logic src, input logic prv);
    case (link_e'(code))
      LNK_SOLO: link_eval = src;
      LNK_AND:  link_eval = src & prv;
      LNK_OR:   link_eval = src | prv;
      default:  link_eval = 1'b0;
    endcase
  endfunction

  // ripple in index order; stage 0 uses its own source as predecessor
  always_comb begin
    logic carry;
    carry = own[0];
    for (int i = 0; i < int'(NWP); i++) begin
      carry    = link_eval(link[2*i +: 2], own[i], carry);
      match[i] = carry;
    end
  end

endmodule

// File: rtl/wpc_counter.sv
module wpc_counter #(
  parameter int unsigned CW = 16,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [2*CW-1:0] ld_data,
  input  logic [IW-1:0] inc_amt,
  output logic [CW-1:0] count,
  output logic          at_limit
);

  logic [CW-1:0] cnt_q, cnt_d, lim_q;
  logic          cnt_en;

  always_comb begin
    cnt_en = ld || (inc_amt != '0);
    if (ld) cnt_d = ld_data[CW-1:0];
    else    cnt_d = cnt_q + CW'(inc_amt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (ld)     lim_q <= ld_data[2*CW-1:CW];
    end
  end

  assign count    = cnt_q;
  assign at_limit = (cnt_q == lim_q);

endmodule

// File: rtl/wpchain_unit.sv
// Link codes occupy 2*(NHIT+3) bits of the write data, so NHIT <= CW-3.
module wpchain_unit
  import wpc_pkg::*;
#(
  parameter  int unsigned NHIT = 8,
  parameter  int unsigned CW   = 16,
  parameter  int unsigned AW   = 3,
  localparam int unsigned NWP  = NHIT + 3,
  localparam int unsigned DW   = 2 * CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NHIT-1:0] hit_i,
  input  logic            ext_hit_i,
  input  logic            eval_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [NWP-1:0]  wp_o,
  output logic [CW-1:0]   cnt0_o,
  output logic [CW-1:0]   cnt1_o,
  output logic            brk_o
);

  localparam int unsigned IW   = $clog2(NWP + 1);
  localparam int unsigned NCNT = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  logic [2*NWP-1:0] link_q;
  logic [NWP-1:0]   csel_q, brkm_q;
  logic [1:0]       cen_q, cnt_ld;

  wpc_regs #(.NWP(NWP), .DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .link_q  (link_q),
    .csel_q  (csel_q),
    .brk_q   (brkm_q),
    .cen_q   (cen_q),
    .cnt_ld  (cnt_ld)
  );

  logic [NCNT-1:0]         at_lim;
  logic [NCNT-1:0][CW-1:0] cnt_val;
  logic [NCNT-1:0][IW-1:0] inc_amt;
  logic [NWP-1:0]          own, match, rise;
  logic [NWP-1:0]          wp_q;
  logic                    brk_d, brk_q;

  function automatic logic [IW-1:0] popcnt(input logic [NWP-1:0] v);
    popcnt = '0;
    for (int i = 0; i < int'(NWP); i++) popcnt = popcnt + IW'(v[i]);
  endfunction

  assign own = {ext_hit_i, at_lim[1], at_lim[0], hit_i};

  wpc_chain #(.NWP(NWP)) u_chain (
    .own   (own),
    .link  (link_q),
    .match (match)
  );

  assign rise = match & ~wp_q;

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    logic [NWP-1:0] owned;
    assign owned      = (k == 0) ? ~csel_q : csel_q;
    assign inc_amt[k] = (eval_i && cen_q[k]) ? popcnt(rise & owned) : '0;

    wpc_counter #(.CW(CW), .IW(IW)) u_counter (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .ld       (cnt_ld[k]),
      .ld_data  (wr_data_i),
      .inc_amt  (inc_amt[k]),
      .count    (cnt_val[k]),
      .at_limit (at_lim[k])
    );
  end

  assign brk_d = eval_i && |(rise & brkm_q);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      wp_q  <= '0;
      brk_q <= 1'b0;
    end else begin
      if (eval_i) wp_q <= match;
      brk_q <= brk_d;
    end
  end

  assign wp_o   = wp_q;
  assign brk_o  = brk_q;
  assign cnt0_o = cnt_val[0];
  assign cnt1_o = cnt_val[1];

endmodule

// File: rtl/wpchain_unit_chk.sv
module wpchain_unit_chk #(
  parameter int unsigned NWP = 11,
  parameter int unsigned CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           eval_i,
  input logic           wr_en_i,
  input logic [NWP-1:0] wp_o,
  input logic [CW-1:0]  cnt0_o,
  input logic [CW-1:0]  cnt1_o,
  input logic           brk_o
);

  assert_brk_after_eval_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> $past(eval_i));

  assert_brk_has_wp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> (wp_o != '0));

  assert_wp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> $stable(wp_o));

  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_i && !wr_en_i) |=> ($stable(cnt0_o) && $stable(cnt1_o)));

endmodule

bind wpchain_unit wpchain_unit_chk #(.NWP(NWP), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .eval_i  (eval_i),
  .wr_en_i (wr_en_i),
  .wp_o    (wp_o),
  .cnt0_o  (cnt0_o),
  .cnt1_o  (cnt1_o),
  .brk_o   (brk_o)
);

// File: tb/wpchain_unit_test.sv
module wpchain_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  hit_i;
  logic        ext_hit_i, eval_i, wr_en_i;
  logic [2:0]  wr_addr_i;
  logic [31:0] wr_data_i;
  logic [10:0] wp_o;
  logic [15:0] cnt0_o, cnt1_o;
  logic        brk_o;

  always #5 clk = ~clk;

  wpchain_unit #(.NHIT(8), .CW(16), .AW(3)) uut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .ext_hit_i(ext_hit_i),
    .eval_i(eval_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .wp_o(wp_o), .cnt0_o(cnt0_o),
    .cnt1_o(cnt1_o), .brk_o(brk_o)
  );

  typedef struct {
    logic [10:0] wp;
    logic [15:0] c0, c1;
    logic        brk;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // reference state, built from the requirement text
  logic [10:0] m_wp, m_sel, m_bmask;
  logic [15:0] m_cnt[2], m_lim[2];
  logic [1:0]  m_code[11];
  logic [1:0]  m_en;

  task automatic step(input logic [7:0] h, input logic x, input logic ev,
                      input logic we, input logic [2:0] a, input logic [31:0] d,
                      input string tag);
    exp_t        e;
    logic [10:0] cur, nw;
    logic        src, prv, b;
    int          add0, add1;
    @(negedge clk);
    hit_i = h; ext_hit_i = x; eval_i = ev;
    wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    @(posedge clk);
    b = 0; add0 = 0; add1 = 0; cur = '0;
    if (ev) begin
      for (int i = 0; i < 11; i++) begin
        if (i < 8)       src = h[i];
        else if (i == 8) src = (m_cnt[0] == m_lim[0]);
        else if (i == 9) src = (m_cnt[1] == m_lim[1]);
        else             src = x;
        prv = (i == 0) ? src : cur[i-1];
        case (m_code[i])
          2'd0: cur[i] = src;
          2'd1: cur[i] = src && prv;
          2'd2: cur[i] = src || prv;
          default: cur[i] = 1'b0;
        endcase
      end
      nw = cur & ~m_wp;
      for (int i = 0; i < 11; i++) begin
        if (nw[i]) begin
          if (m_bmask[i]) b = 1;
          if (m_sel[i]) add1++; else add0++;
        end
      end
      if (m_en[0]) m_cnt[0] = m_cnt[0] + 16'(add0);
      if (m_en[1]) m_cnt[1] = m_cnt[1] + 16'(add1);
      m_wp = cur;
    end
    if (we) begin
      case (a)
        3'd0: for (int i = 0; i < 11; i++) m_code[i] = d[2*i +: 2];
        3'd1: m_sel   = d[10:0];
        3'd2: m_bmask = d[10:0];
        3'd3: m_en    = d[1:0];
        3'd4: begin m_cnt[0] = d[15:0]; m_lim[0] = d[31:16]; end
        3'd5: begin m_cnt[1] = d[15:0]; m_lim[1] = d[31:16]; end
        default: ;
      endcase
    end
    e.wp = m_wp; e.c0 = m_cnt[0]; e.c1 = m_cnt[1]; e.brk = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic ev_(input logic [7:0] h, input logic x, input string tag);
    step(h, x, 1'b1, 1'b0, 3'd0, 32'd0, tag);
  endtask

  task automatic wr_(input logic [2:0] a, input logic [31:0] d, input string tag);
    step(8'h00, 1'b0, 1'b0, 1'b1, a, d, tag);
  endtask

  // monitor: compare the item expected from the last edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (wp_o !== e.wp || cnt0_o !== e.c0 || cnt1_o !== e.c1 || brk_o !== e.brk) begin
        errors++;
        $display("FAIL %s: got wp=%h c0=%h c1=%h brk=%b expected wp=%h c0=%h c1=%h brk=%b",
                 e.tag, wp_o, cnt0_o, cnt1_o, brk_o, e.wp, e.c0, e.c1, e.brk);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_wp = '0; m_sel = '0; m_bmask = '0; m_en = '0;
    for (int i = 0; i < 2; i++) begin m_cnt[i] = '0; m_lim[i] = '0; end
    for (int i = 0; i < 11; i++) m_code[i] = '0;
    rst_n = 1'b0; hit_i = '0; ext_hit_i = 0; eval_i = 0;
    wr_en_i = 0; wr_addr_i = '0; wr_data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    step(8'h00, 0, 0, 0, 3'd0, 32'd0, "R1 reset state");
    wr_(3'd4, 32'hFFFF_0000, "R10 counter0 load");
    wr_(3'd5, 32'hFFFF_0000, "R10 counter1 load");
    ev_(8'hA5, 0, "R2 solo sources");
    ev_(8'h5A, 0, "R4 hit bits map");
    ev_(8'h00, 0, "R2 all clear");
    // wp1 AND, wp2 OR, wp3 off
    wr_(3'd0, 32'h0000_00E4, "R10 link write");
    ev_(8'h0E, 0, "R3 and/or with low predecessor");
    ev_(8'h03, 0, "R3 and/or with high predecessor");
    ev_(8'h08, 0, "R2 code 3 never matches");
    // wp10 solo, then wp10 AND with wp9
    wr_(3'd0, 32'h0000_0000, "R10 link clear");
    ev_(8'h00, 1, "R5 external hit");
    wr_(3'd0, 32'h0010_0000, "R10 link wp10 and");
    ev_(8'h00, 1, "R5 external and-chained");
    step(8'hFF, 1, 0, 0, 3'd0, 32'd0, "R6 hold without eval");
    step(8'h3C, 0, 0, 0, 3'd0, 32'd0, "R6 hold without eval");
    wr_(3'd0, 32'h0000_0000, "R10 link clear");
    ev_(8'h00, 0, "R6 clear");
    // counters: wp1 -> counter1, break on wp0
    wr_(3'd1, 32'h0000_0002, "R10 select write");
    wr_(3'd2, 32'h0000_0001, "R10 break write");
    wr_(3'd3, 32'h0000_0003, "R10 enable write");
    ev_(8'h01, 0, "R7 R9 rising wp0");
    ev_(8'h01, 0, "R7 R9 held wp0 no action");
    step(8'h00, 0, 0, 0, 3'd0, 32'd0, "R9 pulse ends");
    ev_(8'h00, 0, "R7 clear");
    ev_(8'h03, 0, "R7 two counters");
    ev_(8'h00, 0, "R8 clear");
    ev_(8'h3D, 0, "R8 five into counter0");
    wr_(3'd3, 32'h0000_0002, "R10 enable only counter1");
    ev_(8'h00, 0, "R7 clear");
    ev_(8'h03, 0, "R7 counter0 disabled");
    wr_(3'd3, 32'h0000_0003, "R10 enable both");
    // limit feedback into wp8
    wr_(3'd4, 32'h000A_0009, "R10 counter0 preload");
    ev_(8'h00, 0, "R4 clear");
    ev_(8'h01, 0, "R4 count reaches limit");
    ev_(8'h00, 0, "R4 wp8 from limit");
    ev_(8'h00, 0, "R4 wp8 held");
    // wrap of counter1 then wp9 from limit
    wr_(3'd5, 32'h0000_FFFF, "R10 counter1 preload");
    ev_(8'h02, 0, "R11 counter1 wraps");
    ev_(8'h00, 0, "R11 wp9 from limit");
    // write collides with increment
    step(8'h01, 0, 1, 1, 3'd4, 32'h0020_0003, "R10 write wins");
    ev_(8'h00, 0, "R10 after collision");
    // unmapped addresses change nothing
    wr_(3'd6, 32'hFFFF_FFFF, "R10 unmapped 6");
    wr_(3'd7, 32'hFFFF_FFFF, "R10 unmapped 7");
    ev_(8'h01, 0, "R10 config intact after unmapped");
    wr_(3'd2, 32'h0000_0000, "R10 break clear");
    ev_(8'h00, 0, "R9 clear");
    ev_(8'h01, 0, "R9 no break bit no pulse");
    step(8'h00, 0, 0, 0, 3'd0, 32'd0, "R6 idle drain");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule